// File: doc/BRIEF.md
# Supply Start-up Sequencer with Two-Strike Over-Current Hiccup

This block controls start-up, supply upkeep and fault recovery for an offline switching regulator. It reads digitized comparator flags that tell where the supply rail sits relative to four levels: the turn-on level, the refill level, the turn-off level and the post-fault floor. It also reads a flag that shows whether the drain voltage is high enough to feed the high-voltage charger, the live gate state, and two per-cycle fault flags that a switching-cycle strobe qualifies. From these it drives the charger enable, the switch run enable, a latched-fault flag and a low-power flag.

A three-state machine moves between lockout, run and latched fault. In lockout the charger fills the supply capacitor until the turn-on flag appears. In run the switch may operate, and the charger only tops up the rail during gate off-time once the rail has sagged under the refill level. Over-current is filtered so that a lone tripped cycle only raises a warning. A run of consecutive tripped strobes confirms the fault. A brownout strobe latches a fault at once. A latched fault blocks both switching and self-supply until the rail decays below the floor, which gives slow hiccup restarts.

Top module: `hiccup_supervisor`

## Requirements
- R1: During reset and right after it the block is in lockout: run_en=0, fault_latched=0, low_pwr=1, and chg_en equals drain_ok.
- R2: In lockout, chg_en follows drain_ok. On the first clock edge that samples vcc_above_on=1, the block enters run: run_en=1, low_pwr=0, and chg_en falls to 0.
- R3: In run, a clock edge that samples vcc_above_off=0 with no confirmed fault returns the block to lockout with run_en=0.
- R4: In run, an edge that samples vcc_above_refill=0 arms refill. An armed refill holds until an edge samples vcc_above_on=1. While it is armed, chg_en = drain_ok AND NOT gate_on.
- R5: A single strobe (cyc_stb=1) with ocp_trip=1 only raises a warning and latches no fault. A strobe with ocp_trip=0 clears the warning.
- R6: OCP_STRIKES consecutive strobes with ocp_trip=1 (default 2) latch a fault at the edge of the last one. The strike that follows a warning counts as the second strike. ocp_trip outside a strobe has no effect.
- R7: A strobe with bo_low=1 in run latches a fault at that edge. bo_low without a strobe has no effect.
- R8: While a fault is latched: fault_latched=1, low_pwr=1, run_en=0 and chg_en=0. This state persists while vcc_above_floor=1, whatever the other supply flags do.
- R9: An edge that samples vcc_above_floor=0 during a fault clears the latch and enters lockout with charging allowed. The restart then happens at the normal turn-on flag.
- R10: When a fault is confirmed on the same edge that samples vcc_above_off=0, the fault wins and the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drain_ok | input | 1 | Drain voltage above the charger start level |
| vcc_above_on | input | 1 | Supply at or above the turn-on level |
| vcc_above_refill | input | 1 | Supply at or above the refill level |
| vcc_above_off | input | 1 | Supply at or above the turn-off level |
| vcc_above_floor | input | 1 | Supply at or above the post-fault floor |
| gate_on | input | 1 | Switch gate currently driven high |
| cyc_stb | input | 1 | One-cycle strobe per switching cycle |
| ocp_trip | input | 1 | Over-current comparator tripped this cycle |
| bo_low | input | 1 | Sense current too low during on-time this cycle |
| chg_en | output | 1 | High-voltage charger enable |
| run_en | output | 1 | Switch run enable; gate is held low when 0 |
| fault_latched | output | 1 | Confirmed fault is latched |
| low_pwr | output | 1 | Not switching, reduced consumption |

## Verification
The over-current filter gets isolated tripped strobes separated by clean ones, back-to-back tripped strobes, and trips held between strobes. These patterns separate a real two-strike count from a single-hit trigger, from a filter that never resets, and from one that samples without the strobe. The supply flags are walked through sag-and-recover sequences, with the gate toggled, to tell refill gating by off-time and drain level apart from plain lockout charging. Fault recovery is driven with the on/off flags cycling while the floor flag stays high. This shows that only the floor releases the latch. A final case sets a fault and an under-voltage on the same edge to pin down the priority.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/hs_ocp_filter.sv
module hs_ocp_filter #(
  parameter int STRIKES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic stb,
  input  logic trip,
  output logic confirm
);
  localparam int CW = $clog2(STRIKES + 1);
  localparam logic [CW-1:0] LAST = CW'(STRIKES - 1);

  logic [CW-1:0] hits;

  // consecutive tripped strobes seen so far
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits <= '0;
    end else if (!active) begin
      hits <= '0;
    end else if (stb) begin
      if (!trip) hits <= '0;
      else if (hits != LAST) hits <= hits + 1'b1;
    end
  end

  assign confirm = active && stb && trip && (hits == LAST);
endmodule

// File: rtl/hs_refill_ctl.sv
module hs_refill_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic below_refill,
  input  logic reached_on,
  output logic refill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refill <= 1'b0;
    else if (!active || reached_on) refill <= 1'b0;
    else if (below_refill) refill <= 1'b1;
  end
endmodule

// File: rtl/hs_uvlo_fsm.sv
module hs_uvlo_fsm
  import hiccup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_on,
  input  logic       above_off,
  input  logic       above_floor,
  input  logic       fault_evt,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_LOCK:  if (above_on) nxt = ST_RUN;
      ST_RUN: begin
        if (fault_evt)      nxt = ST_FAULT;
        else if (!above_off) nxt = ST_LOCK;
      end
      ST_FAULT: if (!above_floor) nxt = ST_LOCK;
      default:  nxt = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOCK;
    else        state <= nxt;
  end
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
  import hiccup_pkg::*;
#(
  parameter int OCP_STRIKES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drain_ok,
  input  logic vcc_above_on,
  input  logic vcc_above_refill,
  input  logic vcc_above_off,
  input  logic vcc_above_floor,
  input  logic gate_on,
  input  logic cyc_stb,
  input  logic ocp_trip,
  input  logic bo_low,
  output logic chg_en,
  output logic run_en,
  output logic fault_latched,
  output logic low_pwr
);
  seq_state_t state;
  logic       running;
  logic       ocp_confirm;
  logic       bo_evt;
  logic       refill;

  assign running = (state == ST_RUN);
  assign bo_evt  = running && cyc_stb && bo_low;

  hs_ocp_filter #(.STRIKES(OCP_STRIKES)) u_ocp (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (running),
    .stb     (cyc_stb),
    .trip    (ocp_trip),
    .confirm (ocp_confirm)
  );

  hs_refill_ctl u_refill (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (running),
    .below_refill (!vcc_above_refill),
    .reached_on   (vcc_above_on),
    .refill       (refill)
  );

  hs_uvlo_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .above_on    (vcc_above_on),
    .above_off   (vcc_above_off),
    .above_floor (vcc_above_floor),
    .fault_evt   (ocp_confirm || bo_evt),
    .state       (state)
  );

  always_comb begin
    chg_en = 1'b0;
    if (drain_ok) begin
      if (state == ST_LOCK) chg_en = 1'b1;
      else if (running && refill && !gate_on) chg_en = 1'b1;
    end
  end

  assign run_en        = running;
  assign fault_latched = (state == ST_FAULT);
  assign low_pwr       = !running;
endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic drain_ok,
  input logic vcc_above_on,
  input logic vcc_above_off,
  input logic vcc_above_floor,
  input logic gate_on,
  input logic cyc_stb,
  input logic chg_en,
  input logic run_en,
  input logic fault_latched
);
  AST_CHG_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> drain_ok); // R2
  AST_RUN_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(vcc_above_on)); // R2
  AST_UV_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !vcc_above_off && !cyc_stb) |=> !run_en); // R3
  AST_REFILL_OFFTIME: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && run_en) |-> !gate_on); // R4
  AST_FAULT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(cyc_stb)); // R6
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (!run_en && !chg_en)); // R8
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && vcc_above_floor) |=> fault_latched); // R8
  AST_FAULT_EXIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_latched) |-> !$past(vcc_above_floor)); // R9
endmodule

bind hiccup_supervisor hiccup_supervisor_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .drain_ok        (drain_ok),
  .vcc_above_on    (vcc_above_on),
  .vcc_above_off   (vcc_above_off),
  .vcc_above_floor (vcc_above_floor),
  .gate_on         (gate_on),
  .cyc_stb         (cyc_stb),
  .chg_en          (chg_en),
  .run_en          (run_en),
  .fault_latched   (fault_latched)
);

// File: tb/hiccup_supervisor_tb.sv
module hiccup_supervisor_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drain_ok = 1'b0, v_on = 1'b0, v_refill = 1'b0, v_off = 1'b0, v_floor = 1'b1;
  logic gate_on = 1'b0, cyc_stb = 1'b0, ocp_trip = 1'b0, bo_low = 1'b0;
  logic chg_en, run_en, fault_latched, low_pwr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_supervisor u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .drain_ok         (drain_ok),
    .vcc_above_on     (v_on),
    .vcc_above_refill (v_refill),
    .vcc_above_off    (v_off),
    .vcc_above_floor  (v_floor),
    .gate_on          (gate_on),
    .cyc_stb          (cyc_stb),
    .ocp_trip         (ocp_trip),
    .bo_low           (bo_low),
    .chg_en           (chg_en),
    .run_en           (run_en),
    .fault_latched    (fault_latched),
    .low_pwr          (low_pwr)
  );

  // expected vector order: {chg_en, run_en, fault_latched, low_pwr}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    #1;
    got = {chg_en, run_en, fault_latched, low_pwr};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic strobe(input logic trip, input logic bo);
    cyc_stb = 1'b1; ocp_trip = trip; bo_low = bo;
    step();
    cyc_stb = 1'b0; ocp_trip = 1'b0; bo_low = 1'b0;
  endtask

  task automatic supply_good();
    v_floor = 1'b1; v_off = 1'b1; v_refill = 1'b1; v_on = 1'b1;
  endtask

  task automatic recover();
    v_on = 1'b0; v_off = 1'b0; v_refill = 1'b0; v_floor = 1'b0;
    step();
    supply_good();
    step();
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 reset, drain low", 4'b0001);
    drain_ok = 1'b1;
    chk("R1 reset, drain high", 4'b1001);
    rst_n = 1'b1;
    step();
    chk("R1 lockout after reset", 4'b1001);
  endtask

  task automatic t_startup();
    drain_ok = 1'b0;
    chk("R2 lockout no drain", 4'b0001);
    drain_ok = 1'b1;
    v_floor = 1'b1; v_off = 1'b1; v_refill = 1'b1;
    step();
    chk("R2 still charging below on", 4'b1001);
    v_on = 1'b1;
    step();
    chk("R2 run entry", 4'b0100);
  endtask

  task automatic t_refill();
    v_on = 1'b0; v_refill = 1'b0;
    step();
    chk("R4 refill off-time", 4'b1100);
    gate_on = 1'b1;
    chk("R4 refill blocked by gate", 4'b0100);
    gate_on = 1'b0; drain_ok = 1'b0;
    chk("R4 refill blocked by drain", 4'b0100);
    drain_ok = 1'b1; v_refill = 1'b1;
    step();
    chk("R4 refill held above refill", 4'b1100);
    v_on = 1'b1;
    step();
    chk("R4 refill ends at on", 4'b0100);
  endtask

  task automatic t_uv();
    v_on = 1'b0; v_refill = 1'b0; v_off = 1'b0;
    step();
    chk("R3 uv to lockout", 4'b1001);
    supply_good();
    step();
    chk("R3 restart", 4'b0100);
  endtask

  task automatic t_single_strike();
    strobe(1'b1, 1'b0);
    chk("R5 one strike warns only", 4'b0100);
    strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R5 warning cleared by clean strobe", 4'b0100);
    strobe(1'b0, 1'b0);
  endtask

  task automatic t_off_strobe();
    strobe(1'b1, 1'b0);
    ocp_trip = 1'b1;
    step(3);
    ocp_trip = 1'b0;
    chk("R6 trip without strobe ignored", 4'b0100);
    strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R6 non-strobe trips not counted", 4'b0100);
    strobe(1'b0, 1'b0);
  endtask

  task automatic t_double_strike();
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R6 second strike latches", 4'b0011);
    v_on = 1'b0; v_refill = 1'b0; v_off = 1'b0;
    step(2);
    chk("R8 fault holds under uv", 4'b0011);
    v_on = 1'b1;
    step();
    chk("R8 fault ignores on flag", 4'b0011);
    v_on = 1'b0; v_floor = 1'b0;
    step();
    chk("R9 floor clears fault", 4'b1001);
    v_floor = 1'b1; v_off = 1'b1; v_refill = 1'b1;
    step();
    chk("R9 charging below on", 4'b1001);
    v_on = 1'b1;
    step();
    chk("R9 restart at on", 4'b0100);
  endtask

  task automatic t_brownout();
    bo_low = 1'b1;
    step(2);
    bo_low = 1'b0;
    chk("R7 brownout without strobe ignored", 4'b0100);
    strobe(1'b0, 1'b1);
    chk("R7 brownout latches", 4'b0011);
    recover();
    chk("R7 recovered", 4'b0100);
  endtask

  task automatic t_priority();
    strobe(1'b1, 1'b0);
    v_off = 1'b0; v_on = 1'b0; v_refill = 1'b0;
    strobe(1'b1, 1'b0);
    chk("R10 fault beats uv", 4'b0011);
    recover();
    chk("R10 recovered", 4'b0100);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_refill();
    t_uv();
    t_single_strike();
    t_off_strobe();
    t_double_strike();
    t_brownout();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule